// File: doc/BRIEF.md
# I2C Control Register Slave

This block is a two-wire serial slave for the power controller of a satellite receiver front end. It holds one 8-bit system register. The low six bits are control outputs that the rest of the chip uses. The top two bits are live diagnostic flags that software can read but cannot write. The block samples SCL and SDA on the system clock and finds START and STOP conditions. It matches a 7-bit address that a 2-bit select input can move, and it drives SDA low through an open-drain enable to acknowledge.

On a write transfer, each data byte that follows the address replaces the six control bits. On a read transfer, the slave sends the assembled register, MSB first. It sends the register again after every acknowledge from the master, and stops when the master does not acknowledge.

While the undervoltage lockout input is high, the slave clears the control bits to zero, drops any transfer in progress and stays silent on the bus.

Top module: `sup_ctrl_i2c_slave`

## Requirements
- R1: After reset, `ctrl_o` is all zeros and `sda_oe` is low, so SDA is released.
- R2: The slave acknowledges an address byte whose upper seven bits equal 0001000 plus `addr_sel`, that is 0x08 to 0x0B. Bit 0 of the address byte selects read (1) or write (0). For any other address the slave gives no acknowledge and leaves SDA released until the next START.
- R3: In a write transfer, the slave acknowledges each data byte. Bits [5:0] of the byte appear on `ctrl_o[5:0]` a few clock cycles after the SCL falling edge that ends the eighth data bit. Bits [7:6] of a written byte have no effect.
- R4: Several data bytes in one write transfer are each acknowledged and each applied in turn, so the last complete byte decides `ctrl_o`.
- R5: In a read transfer, the slave sends {`ovld_flag_i`, `otemp_flag_i`, `ctrl_o[5:0]`} MSB first. Bit 7 is the overload flag and bit 6 is the over-temperature flag.
- R6: After a master acknowledge on the ninth clock of a read byte, the slave sends the register again. After a master not-acknowledge it releases SDA and ignores SCL until the next START.
- R7: While `uvlo_i` is high, `ctrl_o` goes to zero on the next clock, no byte is acknowledged and no write takes effect. When `uvlo_i` falls, the register stays at zero until it is written.
- R8: A STOP received in the middle of a byte abandons the transfer without changing `ctrl_o`. A START at any point abandons the current transfer and begins a new address phase.
- R9: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low (open drain) |
| addr_sel | input | 2 | Added to base address 0001000 |
| uvlo_i | input | 1 | Supply undervoltage lockout, active high |
| ovld_flag_i | input | 1 | Overload diagnostic, returned in bit 7 |
| otemp_flag_i | input | 1 | Over-temperature diagnostic, returned in bit 6 |
| ctrl_o | output | 6 | Writable control bits of the register |

## Verification
The in-line assertions check these rules on every cycle:
- lockout clears the control bits and releases SDA on the next clock;
- the control bits change only after a completed write byte or a lockout;
- the slave enters the address-acknowledge state only after a matching address;
- a STOP returns the slave to idle;
- the SDA drive never asserts while SCL is high.

Only the bench scenarios can show the following: the exact bit order of read data, the repeated-read behaviour under ack and not-ack, the last-byte-wins rule for multi-byte writes, the select-dependent address match, and how a transfer recovers after an aborted byte.

// File: rtl/sup_ctrl_pkg.sv
package sup_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } bus_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/sup_bus_sync.sv
module sup_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  // SDA edge while SCL is high on both samples
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/sup_ctrl_reg.sv
module sup_ctrl_reg #(
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo_i,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ovld_flag_i,
  input  logic              otemp_flag_i,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W+1:0] rd_word
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (uvlo_i)     ctrl_d = '0;
    else if (wr_en) ctrl_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign rd_word = {ovld_flag_i, otemp_flag_i, ctrl_q};

  // R7
  uvlo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (ctrl_q == '0));

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> ($past(wr_en) || $past(uvlo_i)));
endmodule

// File: rtl/sup_ctrl_i2c_slave.sv
module sup_ctrl_i2c_slave
  import sup_ctrl_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h08,
  parameter int         SEL_W       = 2,
  parameter int         CTRL_W      = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic              uvlo_i,
  input  logic              ovld_flag_i,
  input  logic              otemp_flag_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] my_addr;
  logic [CTRL_W+1:0] rd_word;
  logic wr_en;

  bus_state_e state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shr_q, shr_d, tx_q, tx_d;
  logic oe_q, oe_d, mack_q, mack_d;

  assign my_addr = BASE_ADDR + 7'(addr_sel);

  sup_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sup_ctrl_reg #(.CTRL_W(CTRL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i), .wr_en(wr_en),
    .wr_data(shr_q[CTRL_W-1:0]), .ovld_flag_i(ovld_flag_i),
    .otemp_flag_i(otemp_flag_i), .ctrl_q(ctrl_o), .rd_word(rd_word)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shr_d   = shr_q;
    tx_d    = tx_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    if (uvlo_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            shr_d = {shr_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (state_q == ST_WDAT) begin
              wr_en   = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WACK;
            end else if (shr_q[7:1] == my_addr) begin
              oe_d    = 1'b1;
              state_d = ST_AACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (shr_q[0]) begin
              tx_d    = rd_word;
              oe_d    = ~rd_word[BYTE_W-1];
              state_d = ST_RDAT;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WDAT;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == FULL) begin
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              oe_d = ~tx_q[3'd7 - cnt_q[2:0]];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d    = rd_word;
              oe_d    = ~rd_word[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_RDAT;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shr_q   <= shr_d;
      tx_q    <= tx_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe = oe_q;

  // R7
  uvlo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> !oe_q);

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !$past(scl_s));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !uvlo_i) |=> (state_q == ST_IDLE));

  // R2
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AACK && $past(state_q) != ST_AACK) |-> ($past(shr_q[7:1]) == my_addr));
endmodule

// File: tb/sup_ctrl_i2c_slave_bench.sv
module sup_ctrl_i2c_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic uvlo = 1'b0, ovld = 1'b0, otemp = 1'b0;
  logic sda_oe;
  logic [5:0] ctrl;
  logic sda_line;

  int errors = 0, checks = 0, r9_viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  sup_ctrl_i2c_slave u_sup_ctrl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .uvlo_i(uvlo), .ovld_flag_i(ovld), .otemp_flag_i(otemp),
    .ctrl_o(ctrl)
  );

  // R9 monitor: drive may change only while SCL is low
  always @(negedge clk) begin
    if (rst_n && m_scl && sda_oe !== prev_oe) r9_viol++;
    prev_oe <= sda_oe;
  end

  function automatic logic [6:0] exp_addr(input logic [1:0] sel);
    return 7'h08 + 7'(sel);
  endfunction

  function automatic logic [7:0] exp_read(input logic [5:0] c, input logic ov, input logic ot);
    return {ov, ot, c};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_scl = 1'b0; waitq(Q);
    m_sda = b;    waitq(Q);
    m_scl = 1'b1; waitq(Q);
    s = sda_line; waitq(Q);
  endtask

  task automatic bus_start();
    m_scl = 1'b0; waitq(Q);
    m_sda = 1'b1; waitq(Q);
    m_scl = 1'b1; waitq(Q);
    m_sda = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; waitq(Q);
    m_sda = 1'b0; waitq(Q);
    m_scl = 1'b1; waitq(Q);
    m_sda = 1'b1; waitq(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(!mack, s);
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string req);
    bit ack;
    bus_start();
    wr_byte({a, 1'b0}, ack);
    chk(ack, {req, " addr ack"}, ack, 1);
    wr_byte(d, ack);
    chk(ack, {req, " data ack"}, ack, 1);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] e, input string req);
    bit ack;
    logic [7:0] v;
    bus_start();
    wr_byte({a, 1'b1}, ack);
    chk(ack, {req, " read addr ack"}, ack, 1);
    rd_byte(1'b0, v);
    chk(v == e, req, v, e);
    bus_stop();
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v, d;
    logic [5:0] model;
    void'($urandom(32'd4242));
    waitq(5);
    rst_n = 1'b1;
    waitq(5);
    // R1 reset state
    chk(ctrl == 6'd0, "R1 ctrl", ctrl, 0);
    chk(sda_oe == 1'b0, "R1 sda", sda_oe, 0);
    model = 6'd0;

    // R2, R3, R5 directed per select code
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      d = 8'($urandom);
      do_write(exp_addr(addr_sel), d, "R3");
      model = d[5:0];
      chk(ctrl == model, "R3 ctrl", ctrl, model);
      ovld = 1'($urandom); otemp = 1'($urandom);
      do_read(exp_addr(addr_sel), exp_read(model, ovld, otemp), "R5");
      // R2 neighbour address gets no ack
      bus_start();
      wr_byte({exp_addr(addr_sel + 2'd1), 1'b0}, ack);
      chk(!ack, "R2 wrong addr nack", ack, 0);
      wr_byte(8'h3F, ack);
      chk(!ack && ctrl == model, "R2 ignored data", ctrl, model);
      bus_stop();
    end
    // R2 distant address
    bus_start();
    wr_byte({7'h50, 1'b1}, ack);
    chk(!ack, "R2 far addr", ack, 0);
    bus_stop();

    // R3 upper bits ignored
    addr_sel = 2'd2;
    do_write(exp_addr(addr_sel), 8'hC0, "R3");
    model = 6'd0;
    chk(ctrl == 6'd0, "R3 upper bits", ctrl, 0);

    // R4 multi-byte write
    bus_start();
    wr_byte({exp_addr(addr_sel), 1'b0}, ack);
    wr_byte(8'h15, ack);
    chk(ack && ctrl == 6'h15, "R4 first byte", ctrl, 6'h15);
    wr_byte(8'h2A, ack);
    chk(ack, "R4 second ack", ack, 1);
    bus_stop();
    model = 6'h2A;
    chk(ctrl == model, "R4 last wins", ctrl, model);

    // R6 repeated read then nack
    ovld = 1'b1; otemp = 1'b0;
    bus_start();
    wr_byte({exp_addr(addr_sel), 1'b1}, ack);
    rd_byte(1'b1, v);
    chk(v == exp_read(model, 1'b1, 1'b0), "R6 byte1", v, exp_read(model, 1'b1, 1'b0));
    otemp = 1'b1;
    rd_byte(1'b1, v);
    chk(v == exp_read(model, 1'b1, 1'b1), "R6 byte2", v, exp_read(model, 1'b1, 1'b1));
    rd_byte(1'b0, v);
    chk(v == exp_read(model, 1'b1, 1'b1), "R6 byte3", v, exp_read(model, 1'b1, 1'b1));
    // after nack: extra clocks must see SDA released
    wr_byte(8'h00, ack);
    chk(!ack && sda_oe == 1'b0, "R6 released", sda_oe, 0);
    bus_stop();

    // R8 stop mid-byte
    bus_start();
    wr_byte({exp_addr(addr_sel), 1'b0}, ack);
    for (int i = 0; i < 4; i++) begin
      logic s;
      clk_bit(1'b1, s);
    end
    bus_stop();
    chk(ctrl == model, "R8 stop abort", ctrl, model);
    // R8 repeated start mid-byte
    bus_start();
    wr_byte({exp_addr(addr_sel), 1'b0}, ack);
    for (int i = 0; i < 3; i++) begin
      logic s;
      clk_bit(1'b0, s);
    end
    bus_start();
    wr_byte({exp_addr(addr_sel), 1'b1}, ack);
    chk(ack, "R8 restart ack", ack, 1);
    rd_byte(1'b0, v);
    chk(v == exp_read(model, ovld, otemp), "R8 restart read", v, exp_read(model, ovld, otemp));
    bus_stop();

    // R7 lockout
    uvlo = 1'b1;
    waitq(3);
    chk(ctrl == 6'd0, "R7 cleared", ctrl, 0);
    bus_start();
    wr_byte({exp_addr(addr_sel), 1'b0}, ack);
    chk(!ack, "R7 no ack", ack, 0);
    wr_byte(8'h3F, ack);
    bus_stop();
    chk(ctrl == 6'd0, "R7 write ignored", ctrl, 0);
    uvlo = 1'b0;
    waitq(3);
    chk(ctrl == 6'd0, "R7 stays zero", ctrl, 0);
    model = 6'd0;
    do_write(exp_addr(addr_sel), 8'h09, "R7 recover");
    model = 6'h09;
    chk(ctrl == model, "R7 recover ctrl", ctrl, model);

    // random mix of writes and reads
    for (int n = 0; n < 20; n++) begin
      addr_sel = 2'($urandom);
      d = 8'($urandom);
      do_write(exp_addr(addr_sel), d, "R3 rand");
      model = d[5:0];
      chk(ctrl == model, "R3 rand ctrl", ctrl, model);
      ovld = 1'($urandom); otemp = 1'($urandom);
      do_read(exp_addr(addr_sel), exp_read(model, ovld, otemp), "R5 rand");
    end

    chk(r9_viol == 0, "R9 drive while SCL high", r9_viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule